// File: doc/BRIEF.md
# Memory-Mapped Multiply and Divide Unit

This block gives a processor with no arithmetic hardware of its own a way to multiply and divide unsigned bytes. It sits on a simple register bus and takes up four byte locations. Each location has two meanings. A write loads an operand. A read at the same location returns one slice of a result that is always computed from the operand values currently held.

Two locations serve the multiplier: the two factors go in, and the low and high bytes of the double-width product come out. The other two serve the divider: dividend and divisor go in, and the quotient and remainder come out. Software writes the operands it needs and reads the result on any later cycle. The unit has no start command and no busy state.

The result registers take their value from the operands as they will be after the current write. A read in the cycle right after a write therefore already sees the new result.

Top module: `arith_mmio`

## Requirements
- R1: After reset all four operands are zero. Reads then return 0x00 at offset 0, 0x00 at offset 1, 0xFF at offset 2 and 0x00 at offset 3.
- R2: A write to offset 0 stores the multiplicand. A read at offset 0 returns bits 7:0 of the unsigned product multiplicand × multiplier.
- R3: A write to offset 1 stores the multiplier. A read at offset 1 returns bits 15:8 of the unsigned product.
- R4: A write to offset 2 stores the dividend. With a non-zero divisor, a read at offset 2 returns the truncated unsigned quotient dividend / divisor.
- R5: A write to offset 3 stores the divisor. With a non-zero divisor, a read at offset 3 returns dividend mod divisor, which is always less than the divisor.
- R6: When the divisor is zero, a read at offset 2 returns 0xFF and a read at offset 3 returns the dividend.
- R7: A write captured at a rising edge is reflected in every result read in the next cycle. No idle cycle is needed between a write and a read.
- R8: While the select input is low, writes are ignored and the read data output is 0x00. The read data output is also 0x00 during a selected write.
- R9: A write changes only the operand at its own offset. Results that do not depend on that operand keep their value.
- R10: Reads have no side effect: reading any offset repeatedly returns the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Selects the unit for this cycle |
| bus_we | input | 1 | 1 = write an operand, 0 = read a result |
| bus_addr | input | 2 | Register offset 0..3 |
| bus_wdata | input | 8 | Operand byte for a write |
| bus_rdata | output | 8 | Result byte for a selected read, 0x00 otherwise |

## Verification
The hardest case to reach is a read issued in the very cycle after the write that changes its result. A model that is one cycle late would still pass any test that leaves an idle gap. The sweep therefore always reads the result that depends on the operand it has just written, with no gap, and only then reads the other result. Divide-by-zero and the all-ones boundaries come up inside the same sweep, because the divisor values include 0x00 and 0xFF and the dividend runs over every value. Deselected writes are followed at once by reads of all four offsets, so that any operand they corrupted shows up at the ports.

// File: rtl/arith_mmio_pkg.sv
package arith_mmio_pkg;

    // Register offsets: the low bit picks the operand or result half,
    // the high bit picks the multiply or divide pair.
    typedef enum logic [1:0] {
        OFF_MUL_A = 2'd0,   // write: multiplicand, read: product low byte
        OFF_MUL_B = 2'd1,   // write: multiplier,   read: product high byte
        OFF_DIV_N = 2'd2,   // write: dividend,     read: quotient
        OFF_DIV_D = 2'd3    // write: divisor,      read: remainder
    } reg_off_e;

    localparam int unsigned OFF_BITS = 2;

endpackage

// File: rtl/arith_mmio_opregs.sv
module arith_mmio_opregs
    import arith_mmio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFF_BITS-1:0] wr_addr,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        mcand_d,
    output logic [W-1:0]        mplier_d,
    output logic [W-1:0]        dvd_d,
    output logic [W-1:0]        dvs_d,
    output logic [W-1:0]        mcand_q,
    output logic [W-1:0]        mplier_q,
    output logic [W-1:0]        dvd_q,
    output logic [W-1:0]        dvs_q
);

    typedef struct packed {
        logic [W-1:0] mcand;
        logic [W-1:0] mplier;
        logic [W-1:0] dvd;
        logic [W-1:0] dvs;
    } opr_t;

    opr_t opr_d;
    opr_t opr_q;

    always_comb begin
        opr_d = opr_q;
        if (wr_en) begin
            unique case (reg_off_e'(wr_addr))
                OFF_MUL_A: opr_d.mcand  = wr_data;
                OFF_MUL_B: opr_d.mplier = wr_data;
                OFF_DIV_N: opr_d.dvd    = wr_data;
                OFF_DIV_D: opr_d.dvs    = wr_data;
                default:   opr_d        = opr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opr_q <= '0;
        end else begin
            opr_q <= opr_d;
        end
    end

    assign mcand_d  = opr_d.mcand;
    assign mplier_d = opr_d.mplier;
    assign dvd_d    = opr_d.dvd;
    assign dvs_d    = opr_d.dvs;
    assign mcand_q  = opr_q.mcand;
    assign mplier_q = opr_q.mplier;
    assign dvd_q    = opr_q.dvd;
    assign dvs_q    = opr_q.dvs;

endmodule

// File: rtl/arith_mmio_mul.sv
module arith_mmio_mul #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   fac_a,
    input  logic [W-1:0]   fac_b,
    output logic [2*W-1:0] prod
);

    localparam int unsigned PW = 2 * W;

    // Shift-and-add array: stage i adds fac_a << i when bit i of fac_b is set.
    logic [PW-1:0] acc [0:W];

    assign acc[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_row
        logic [PW-1:0] part;
        assign part       = fac_b[i] ? ({{W{1'b0}}, fac_a} << i) : '0;
        assign acc[i + 1] = acc[i] + part;
    end

    assign prod = acc[W];

endmodule

// File: rtl/arith_mmio_div.sv
module arith_mmio_div #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    // Restoring division unrolled over W stages, most significant bit first.
    logic [W-1:0] part_rem [0:W];
    logic [W-1:0] raw_quo;
    logic         den_zero;

    assign part_rem[0] = '0;

    for (genvar k = 0; k < W; k++) begin : g_stage
        localparam int unsigned J = W - 1 - k;
        logic [W:0] trial;
        logic [W:0] diff;
        logic       fits;
        assign trial           = {part_rem[k], num[J]};
        assign diff            = trial - {1'b0, den};
        assign fits            = trial >= {1'b0, den};
        assign raw_quo[J]      = fits;
        assign part_rem[k + 1] = fits ? diff[W-1:0] : trial[W-1:0];
    end

    assign den_zero = (den == '0);
    assign quo      = den_zero ? '1  : raw_quo;
    assign rem      = den_zero ? num : part_rem[W];

endmodule

// File: rtl/arith_mmio.sv
module arith_mmio
    import arith_mmio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [OFF_BITS-1:0] bus_addr,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata
);

    localparam int unsigned PW = 2 * W;

    typedef struct packed {
        logic [PW-1:0] prod;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
    } res_t;

    logic         wr_en;
    logic         rd_en;
    logic [W-1:0] mcand_d, mplier_d, dvd_d, dvs_d;
    logic [W-1:0] mcand_q, mplier_q, dvd_q, dvs_q;
    logic [PW-1:0] prod_w;
    logic [W-1:0]  quo_w;
    logic [W-1:0]  rem_w;
    res_t          res_d;
    res_t          res_q;

    assign wr_en = bus_sel & bus_we;
    assign rd_en = bus_sel & ~bus_we;

    arith_mmio_opregs #(.W(W)) u_opregs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .mcand_d  (mcand_d),
        .mplier_d (mplier_d),
        .dvd_d    (dvd_d),
        .dvs_d    (dvs_d),
        .mcand_q  (mcand_q),
        .mplier_q (mplier_q),
        .dvd_q    (dvd_q),
        .dvs_q    (dvs_q)
    );

    // Results follow the operands as they stand after this cycle's write.
    arith_mmio_mul #(.W(W)) u_mul (
        .fac_a (mcand_d),
        .fac_b (mplier_d),
        .prod  (prod_w)
    );

    arith_mmio_div #(.W(W)) u_div (
        .num (dvd_d),
        .den (dvs_d),
        .quo (quo_w),
        .rem (rem_w)
    );

    always_comb begin
        res_d      = res_q;
        res_d.prod = prod_w;
        res_d.quo  = quo_w;
        res_d.rem  = rem_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q.prod <= '0;
            res_q.quo  <= '1;   // zero divisor after reset
            res_q.rem  <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (reg_off_e'(bus_addr))
                OFF_MUL_A: bus_rdata = res_q.prod[W-1:0];
                OFF_MUL_B: bus_rdata = res_q.prod[PW-1:W];
                OFF_DIV_N: bus_rdata = res_q.quo;
                OFF_DIV_D: bus_rdata = res_q.rem;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/arith_mmio_chk.sv
module arith_mmio_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel,
    input logic         we,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] mcand,
    input logic [W-1:0] mplier,
    input logic [W-1:0] dvd,
    input logic [W-1:0] dvs
);

    logic [2*W-1:0] ref_prod;
    logic           rd;
    logic           wr;

    assign ref_prod = {{W{1'b0}}, mcand} * {{W{1'b0}}, mplier};
    assign rd       = sel && !we;
    assign wr       = sel && we;

    AST_MUL_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd0) |-> rdata == ref_prod[W-1:0]);              // R2
    AST_MUL_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd1) |-> rdata == ref_prod[2*W-1:W]);            // R3
    AST_DIV_QUO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd2 && dvs != '0) |-> rdata == dvd / dvs);       // R4
    AST_DIV_REM: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd3 && dvs != '0) |-> rdata < dvs);              // R5
    AST_ZERO_QUO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd2 && dvs == '0) |-> rdata == '1);              // R6
    AST_ZERO_REM: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd3 && dvs == '0) |-> rdata == dvd);             // R6
    AST_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0) |=> mcand == $past(wdata));                 // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rdata == '0);                                            // R8
    AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mcand) && $stable(mplier) && $stable(dvd) && $stable(dvs)); // R8
    AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd3) |=> $stable(mcand) && $stable(mplier) && $stable(dvd)); // R9

endmodule

bind arith_mmio arith_mmio_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (bus_sel),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .mcand  (mcand_q),
    .mplier (mplier_q),
    .dvd    (dvd_q),
    .dvs    (dvs_q)
);

// File: tb/arith_mmio_tb.sv
module arith_mmio_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model of operand state
    int m_a = 0, m_b = 0, m_n = 0, m_d = 0;

    always #10 clk = ~clk;   // 50 MHz

    arith_mmio u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic int exp_of(input int off);
        case (off)
            0:       return (m_a * m_b) & 255;
            1:       return ((m_a * m_b) >> 8) & 255;
            2:       return (m_d == 0) ? 255 : m_n / m_d;
            default: return (m_d == 0) ? m_n : m_n % m_d;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input int val);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = 2'(off); bus_wdata = 8'(val);
        case (off)
            0: m_a = val;
            1: m_b = val;
            2: m_n = val;
            default: m_d = val;
        endcase
    endtask

    task automatic rd(input int off, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 2'(off);
        #2;
        check(req, int'(bus_rdata), exp_of(off));
    endtask

    task automatic idle_check();
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #2;
        check("R8 idle", int'(bus_rdata), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, "R1 off0"); rd(1, "R1 off1"); rd(2, "R1 off2"); rd(3, "R1 off3");
        idle_check();

        // sweep: every dividend/multiplicand against 38 divisor/multiplier values
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 38; bi++) begin
                int bv;
                bv = (bi == 37) ? 255 : bi * 7;
                wr(0, ai);
                wr(1, bv);
                rd(1, "R3/R7 hi after write");
                rd(0, "R2 lo");
                rd(2, "R9 quotient kept across multiply writes");
                wr(2, ai);
                wr(3, bv);
                rd(3, (bv == 0) ? "R6/R7 rem" : "R5/R7 rem");
                rd(2, (bv == 0) ? "R6 quo" : "R4 quo");
            end
        end

        // R10: repeated reads
        wr(0, 8'hC3); wr(1, 8'h5B); wr(2, 8'hF1); wr(3, 8'h0D);
        for (int k = 0; k < 4; k++) begin
            rd(k, "R10 first");
            rd(k, "R10 repeat");
        end

        // R8: deselected writes ignored, rdata quiet
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 2'(k); bus_wdata = 8'h5A;
            #2;
            check("R8 deselected write rdata", int'(bus_rdata), 0);
        end
        for (int k = 0; k < 4; k++) rd(k, "R8 operands unchanged");

        // R8: rdata quiet during selected write
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h00;
        m_d = 0;
        #2;
        check("R8 rdata during write", int'(bus_rdata), 0);
        rd(3, "R6 rem after divisor cleared");
        rd(2, "R6 quo after divisor cleared");
        idle_check();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule